// File: doc/BRIEF.md
# Buffered Compare PWM Timer Pair

This block is a pair of timer channels, a master and a slave, driven by one shared up-counter. The master's A register sets the PWM period: the counter runs from 0 up to that value and then returns to 0. Each channel holds four compare registers (A, B, C, D). Six PWM outputs are set when the period ends and drop when the counter reaches their own duty value. Compare-match events set per-register flags. Software clears a flag by reading it and then writing 0 to it.

Two mode bits in the master's control field turn on double-buffering for both channels together. When buffering is on, C feeds A and D feeds B. New duty and period values are written into C or D and are copied into A or B at the end of the period. All these copies happen in one clock cycle, so both channels switch to their new values together. While C or D serves as a buffer, its compare flag is not set. The slave's own buffer bits do not select buffering. The slave's A-buffer bit has one effect: it silences the slave's C-side output.

Register map (4-bit address, data as wide as the counter): 0 control, 1 flags, 2..5 master A..D, 6..9 slave A..D, 10 counter (read only). Writes take effect at the next clock edge. Reads are combinational.

Top module: `tpair_pwm_timer`

## Requirements
- R1: While control bit 0 (run) is 1, the counter (address 10) rises by one per cycle. In the cycle after it equals master A (address 2) it reads 0, so a period lasts master A + 1 cycles.
- R2: Each output `pwm_o[k]` is high for duty + 1 cycles of every period. Duty sources: bit 0 master B, bit 1 master D, bit 2 slave A, bit 3 slave B, bit 4 slave C, bit 5 slave D.
- R3: An output whose duty value is equal to or above master A stays high for the whole period.
- R4: With control bit 1 set, at each period end master C is copied into master A and slave C into slave A, in the same cycle. Before that period end, both A registers keep their values.
- R5: With control bit 2 set, at period end master D is copied into master B and slave D into slave B. Outputs 1 and 5 then take their duty from the B register of their own channel.
- R6: Control bits 3 and 4 (the slave's buffer bits) never cause a copy between slave registers.
- R7: While control bit 3 is 1, `pwm_o[4]` is held low.
- R8: A flag (address 1; bit 0..3 = master A..D, bit 4..7 = slave A..D) is set when the counter equals that register while running. This applies to the A and B registers always.
- R9: The C flags (bits 2 and 6) are never set while control bit 1 is 1, and the D flags (bits 3 and 7) are never set while control bit 2 is 1. Otherwise they are set on a match like any other flag.
- R10: A flag clears only when 0 is written to it after a read that returned it as 1. Writing 1, or writing 0 with no such read, leaves it set.
- R11: While run is 0, the counter and all outputs hold their values.
- R12: After reset, the counter, all registers, all flags and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address for reads and writes |
| wr_en_i | input | 1 | Write strobe, single cycle |
| rd_en_i | input | 1 | Read strobe; arms the read-then-clear rule for flags |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Combinational read data |
| pwm_o | output | 6 | PWM outputs |

## Verification
The bench builds the block with CNT_W = 8. With that width, a duty value of 200 is well above any period the bench uses, so the full-period-high case of R3 is reached in a short run. Periods of 10 to 20 cycles keep every buffer transfer, flag event and clear sequence within a few hundred cycles. High-time counts taken over one full period hold wherever the sampling window starts, so each duty check does not depend on the output phase.

// File: rtl/tpair_pkg.sv
package tpair_pkg;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned NREG   = 4;
    localparam int unsigned NFLG   = 2 * NREG;
    localparam int unsigned NOUT   = 6;

    // register index inside one channel
    localparam int unsigned IX_A = 0;
    localparam int unsigned IX_B = 1;
    localparam int unsigned IX_C = 2;
    localparam int unsigned IX_D = 3;

    // address map
    localparam int unsigned ADR_CTRL = 0;
    localparam int unsigned ADR_FLAG = 1;
    localparam int unsigned ADR_MS0  = 2;
    localparam int unsigned ADR_SL0  = ADR_MS0 + NREG;
    localparam int unsigned ADR_CNT  = ADR_SL0 + NREG;

    // control field, bit 0 is run
    typedef struct packed {
        logic sl_buf_b;
        logic sl_buf_a;
        logic ms_buf_b;
        logic ms_buf_a;
        logic run;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tpair_count.sv
module tpair_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = run_i && (st_q.cnt == period_i);
        if (run_i) begin
            if (wrap_o) st_d.cnt = '0;
            else        st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/tpair_regs.sv
module tpair_regs
    import tpair_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           wr_en_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [CNT_W-1:0]               wdata_i,
    input  logic                           wrap_i,
    output ctrl_t                          ctrl_o,
    output logic [NREG-1:0][CNT_W-1:0]     ms_o,
    output logic [NREG-1:0][CNT_W-1:0]     sl_o
);

    typedef struct packed {
        ctrl_t                          ctrl;
        logic [NREG-1:0][CNT_W-1:0]     ms;
        logic [NREG-1:0][CNT_W-1:0]     sl;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // period-end transfers, selected by the master mode bits only
        if (wrap_i) begin
            if (st_q.ctrl.ms_buf_a) begin
                st_d.ms[IX_A] = st_q.ms[IX_C];
                st_d.sl[IX_A] = st_q.sl[IX_C];
            end
            if (st_q.ctrl.ms_buf_b) begin
                st_d.ms[IX_B] = st_q.ms[IX_D];
                st_d.sl[IX_B] = st_q.sl[IX_D];
            end
        end
        // a software write in the same cycle takes precedence
        if (wr_en_i) begin
            if (addr_i == ADDR_W'(ADR_CTRL)) begin
                st_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
            end
            for (int i = 0; i < NREG; i++) begin
                if (addr_i == ADDR_W'(ADR_MS0 + i)) st_d.ms[i] = wdata_i;
                if (addr_i == ADDR_W'(ADR_SL0 + i)) st_d.sl[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign ms_o   = st_q.ms;
    assign sl_o   = st_q.sl;

endmodule

// File: rtl/tpair_flags.sv
module tpair_flags
    import tpair_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NFLG-1:0] set_i,
    input  logic            rd_arm_i,
    input  logic            wr_i,
    input  logic [NFLG-1:0] wdata_i,
    output logic [NFLG-1:0] flags_o
);

    typedef struct packed {
        logic [NFLG-1:0] flags;
        logic [NFLG-1:0] armed;
    } flg_st_t;

    flg_st_t         st_d, st_q;
    logic [NFLG-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (rd_arm_i) st_d.armed = st_q.flags;
        if (wr_i) begin
            clr         = st_q.armed & ~wdata_i;
            st_d.flags  = st_q.flags & ~clr;
            st_d.armed  = st_d.armed & ~clr;
        end
        // a new match wins over a clear in the same cycle
        st_d.flags = st_d.flags | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/tpair_wave.sv
module tpair_wave (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic wrap_i,
    input  logic hit_i,
    input  logic kill_i,
    output logic pwm_o
);

    typedef struct packed {
        logic lvl;
    } wave_st_t;

    wave_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kill_i) begin
            st_d.lvl = 1'b0;
        end else if (run_i) begin
            if (wrap_i)     st_d.lvl = 1'b1;
            else if (hit_i) st_d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pwm_o = st_q.lvl;

endmodule

// File: rtl/tpair_pwm_timer.sv
module tpair_pwm_timer
    import tpair_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic [NOUT-1:0]   pwm_o
);

    ctrl_t                      ctrl;
    logic [NREG-1:0][CNT_W-1:0] ms_regs;
    logic [NREG-1:0][CNT_W-1:0] sl_regs;
    logic [CNT_W-1:0]           cnt;
    logic                       wrap;
    logic [NFLG-1:0]            flags;
    logic [NFLG-1:0]            flg_set;
    logic [NOUT-1:0][CNT_W-1:0] duty;
    logic [NOUT-1:0]            kill;
    logic                       rd_arm;
    logic                       flg_wr;

    tpair_count #(.CNT_W(CNT_W)) u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (ctrl.run),
        .period_i (ms_regs[IX_A]),
        .cnt_o    (cnt),
        .wrap_o   (wrap)
    );

    tpair_regs #(.CNT_W(CNT_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .wrap_i  (wrap),
        .ctrl_o  (ctrl),
        .ms_o    (ms_regs),
        .sl_o    (sl_regs)
    );

    // compare-match flag requests; C and D stay quiet while buffering
    always_comb begin
        flg_set = '0;
        for (int i = 0; i < NREG; i++) begin
            flg_set[i]        = ctrl.run && (cnt == ms_regs[i]);
            flg_set[NREG + i] = ctrl.run && (cnt == sl_regs[i]);
        end
        if (ctrl.ms_buf_a) begin
            flg_set[IX_C]        = 1'b0;
            flg_set[NREG + IX_C] = 1'b0;
        end
        if (ctrl.ms_buf_b) begin
            flg_set[IX_D]        = 1'b0;
            flg_set[NREG + IX_D] = 1'b0;
        end
    end

    assign rd_arm = rd_en_i && (addr_i == ADDR_W'(ADR_FLAG));
    assign flg_wr = wr_en_i && (addr_i == ADDR_W'(ADR_FLAG));

    tpair_flags u_flags (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (flg_set),
        .rd_arm_i (rd_arm),
        .wr_i     (flg_wr),
        .wdata_i  (wdata_i[NFLG-1:0]),
        .flags_o  (flags)
    );

    // duty source for each output
    always_comb begin
        kill    = '0;
        duty[0] = ms_regs[IX_B];
        duty[1] = ctrl.ms_buf_b ? ms_regs[IX_B] : ms_regs[IX_D];
        duty[2] = sl_regs[IX_A];
        duty[3] = sl_regs[IX_B];
        duty[4] = ctrl.ms_buf_a ? sl_regs[IX_A] : sl_regs[IX_C];
        duty[5] = ctrl.ms_buf_b ? sl_regs[IX_B] : sl_regs[IX_D];
        kill[4] = ctrl.sl_buf_a;
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_wave
        tpair_wave u_wave (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .run_i  (ctrl.run),
            .wrap_i (wrap),
            .hit_i  (cnt == duty[g]),
            .kill_i (kill[g]),
            .pwm_o  (pwm_o[g])
        );
    end

    // combinational read
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(ADR_CTRL)) rdata_o[CTRL_W-1:0] = ctrl;
        if (addr_i == ADDR_W'(ADR_FLAG)) rdata_o[NFLG-1:0]   = flags;
        if (addr_i == ADDR_W'(ADR_CNT))  rdata_o             = cnt;
        for (int i = 0; i < NREG; i++) begin
            if (addr_i == ADDR_W'(ADR_MS0 + i)) rdata_o = ms_regs[i];
            if (addr_i == ADDR_W'(ADR_SL0 + i)) rdata_o = sl_regs[i];
        end
    end

endmodule

// File: rtl/tpair_chk.sv
module tpair_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             run,
    input logic             wrap,
    input logic             ms_buf_a,
    input logic             ms_buf_b,
    input logic             sl_buf_a,
    input logic             wr_en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ms_a,
    input logic [CNT_W-1:0] ms_b,
    input logic [CNT_W-1:0] ms_c,
    input logic [CNT_W-1:0] ms_d,
    input logic [CNT_W-1:0] sl_a,
    input logic [CNT_W-1:0] sl_b,
    input logic [CNT_W-1:0] sl_c,
    input logic [CNT_W-1:0] sl_d,
    input logic [7:0]       flags,
    input logic [5:0]       pwm
);

    // R1
    counter_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> (cnt == '0));

    // R1
    counter_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && !wrap) |=> (cnt == $past(cnt) + 1'b1));

    // R4
    xfer_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap && ms_buf_a && !wr_en) |=> (ms_a == $past(ms_c) && sl_a == $past(sl_c)));

    // R5
    xfer_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap && ms_buf_b && !wr_en) |=> (ms_b == $past(ms_d) && sl_b == $past(sl_d)));

    // R9
    c_flag_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ms_buf_a && !flags[2] && !flags[6]) |=> (!flags[2] && !flags[6]));

    // R9
    d_flag_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ms_buf_b && !flags[3] && !flags[7]) |=> (!flags[3] && !flags[7]));

    // R7
    slave_c_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sl_buf_a |=> !pwm[4]);

    // R11
    hold_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run |=> $stable(cnt));

endmodule

bind tpair_pwm_timer tpair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run      (ctrl.run),
    .wrap     (wrap),
    .ms_buf_a (ctrl.ms_buf_a),
    .ms_buf_b (ctrl.ms_buf_b),
    .sl_buf_a (ctrl.sl_buf_a),
    .wr_en    (wr_en_i),
    .cnt      (cnt),
    .ms_a     (ms_regs[0]),
    .ms_b     (ms_regs[1]),
    .ms_c     (ms_regs[2]),
    .ms_d     (ms_regs[3]),
    .sl_a     (sl_regs[0]),
    .sl_b     (sl_regs[1]),
    .sl_c     (sl_regs[2]),
    .sl_d     (sl_regs[3]),
    .flags    (flags),
    .pwm      (pwm_o)
);

// File: tb/tpair_pwm_timer_tb.sv
module tpair_pwm_timer_tb;

    localparam int unsigned CNT_W = 8;
    localparam logic [3:0] A_CTRL = 4'd0, A_FLAG = 4'd1;
    localparam logic [3:0] A_MA = 4'd2, A_MB = 4'd3, A_MC = 4'd4, A_MD = 4'd5;
    localparam logic [3:0] A_SA = 4'd6, A_SB = 4'd7, A_SC = 4'd8, A_SD = 4'd9;
    localparam logic [3:0] A_CNT = 4'd10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       addr = '0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [CNT_W-1:0] wdata = '0;
    logic [CNT_W-1:0] rdata;
    logic [5:0]       pwm;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int hi [6];

    always #2.5 clk = ~clk;

    tpair_pwm_timer #(.CNT_W(CNT_W)) u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .addr_i  (addr),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .pwm_o   (pwm)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        addr = a; wdata = CNT_W'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            addr = A_CNT;
            #1;
            if (int'(rdata) == v) break;
        end
    endtask

    task automatic measure(input int n);
        for (int k = 0; k < 6; k++) hi[k] = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            for (int k = 0; k < 6; k++) if (pwm[k]) hi[k]++;
        end
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        #1 check("R12 pwm after reset", int'(pwm), 0);
        rd(A_CNT, v);  check("R12 counter after reset", v, 0);
        rd(A_FLAG, v); check("R12 flags after reset", v, 0);
        rd(A_MA, v);   check("R12 master A after reset", v, 0);
    endtask

    task automatic t_duty();
        int prev, cur, bad, mx;
        do_reset();
        wr(A_MA, 9); wr(A_MB, 2); wr(A_MD, 5);
        wr(A_SA, 0); wr(A_SB, 7); wr(A_SC, 9); wr(A_SD, 200);
        wr(A_CTRL, 1);
        repeat (25) @(negedge clk);
        // R1: step and wrap of the counter
        bad = 0; mx = 0;
        @(negedge clk); addr = A_CNT; #1 prev = int'(rdata);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #1 cur = int'(rdata);
            if (cur != ((prev == 9) ? 0 : prev + 1)) bad++;
            if (cur > mx) mx = cur;
            prev = cur;
        end
        check("R1 counter step errors", bad, 0);
        check("R1 counter peak", mx, 9);
        measure(10);
        check("R2 pwm0 master B duty", hi[0], 3);
        check("R2 pwm1 master D duty", hi[1], 6);
        check("R2 pwm2 slave A duty 0", hi[2], 1);
        check("R2 pwm3 slave B duty", hi[3], 8);
        check("R3 pwm4 duty equal period", hi[4], 10);
        check("R3 pwm5 duty above period", hi[5], 10);
        // R11: stop and hold
        wr(A_CTRL, 0);
        @(negedge clk); addr = A_CNT; #1 prev = int'(rdata); cur = int'(pwm);
        repeat (6) @(negedge clk);
        #1 check("R11 counter holds", int'(rdata), prev);
        check("R11 outputs hold", int'(pwm), cur);
    endtask

    task automatic t_buf_a();
        int v;
        do_reset();
        wr(A_MA, 19); wr(A_MC, 19); wr(A_SA, 5); wr(A_SC, 5);
        wr(A_CTRL, 3);
        wait_cnt(2);
        wr(A_MC, 15); wr(A_SC, 12);
        rd(A_MA, v); check("R4 master A before period end", v, 19);
        rd(A_SA, v); check("R4 slave A before period end", v, 5);
        wait_cnt(1);
        rd(A_MA, v); check("R4 master A after period end", v, 15);
        rd(A_SA, v); check("R4 slave A after period end", v, 12);
        repeat (20) @(negedge clk);
        measure(16);
        check("R4 slave A duty in new period", hi[2], 13);
        check("R4 slave C side follows A", hi[4], 13);
    endtask

    task automatic t_buf_b();
        int v;
        do_reset();
        wr(A_MA, 9); wr(A_MB, 1); wr(A_MD, 6);
        wr(A_SA, 3); wr(A_SB, 2); wr(A_SD, 4);
        wr(A_CTRL, 5);
        repeat (30) @(negedge clk);
        rd(A_MB, v); check("R5 master B loaded from D", v, 6);
        rd(A_SB, v); check("R5 slave B loaded from D", v, 4);
        measure(10);
        check("R5 pwm0 master B", hi[0], 7);
        check("R5 pwm1 master D side uses B", hi[1], 7);
        check("R5 pwm3 slave B", hi[3], 5);
        check("R5 pwm5 slave D side uses B", hi[5], 5);
    endtask

    task automatic t_slave_bits();
        int v;
        do_reset();
        wr(A_MA, 9); wr(A_SA, 3); wr(A_SC, 7); wr(A_SB, 2); wr(A_SD, 8);
        wr(A_CTRL, 1 + 8 + 16);
        repeat (30) @(negedge clk);
        rd(A_SA, v); check("R6 slave A not loaded by own bit", v, 3);
        rd(A_SB, v); check("R6 slave B not loaded by own bit", v, 2);
        measure(10);
        check("R7 slave C side output silent", hi[4], 0);
        check("R6 slave A output normal", hi[2], 4);
        rd(A_FLAG, v); check("R9 slave C flag set when not buffered", (v >> 6) & 1, 1);
    endtask

    task automatic t_flags();
        int v;
        do_reset();
        wr(A_MA, 9); wr(A_MB, 4); wr(A_MC, 6); wr(A_MD, 5);
        wr(A_SA, 2); wr(A_SB, 3); wr(A_SC, 5); wr(A_SD, 4);
        wr(A_CTRL, 7);
        repeat (30) @(negedge clk);
        rd(A_FLAG, v); check("R8 R9 flags with both buffers on", v, 'h33);
        do_reset();
        wr(A_MA, 9); wr(A_MB, 4); wr(A_MC, 6); wr(A_MD, 5);
        wr(A_SA, 2); wr(A_SB, 3); wr(A_SC, 5); wr(A_SD, 4);
        wr(A_CTRL, 1);
        repeat (25) @(negedge clk);
        wr(A_CTRL, 0);
        wr(A_FLAG, 0);
        rd(A_FLAG, v); check("R10 write 0 without read keeps flags", v, 'hFF);
        wr(A_FLAG, 'hF0);
        rd(A_FLAG, v); check("R10 read then write clears only zeros", v, 'hF0);
        wr(A_FLAG, 0);
        rd(A_FLAG, v); check("R10 second read then clear", v, 0);
    endtask

    initial begin
        t_reset();
        t_duty();
        t_buf_a();
        t_buf_b();
        t_slave_bits();
        t_flags();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule